// File: doc/BRIEF.md
# Banked Interrupt Controller with Fast-Interrupt Steering

This block collects level-sensitive interrupt requests from two groups of peripheral lines (32 lines per group) and one further "basic" group of 32 lines. Every group has a read-only pending word that shows the live level of its inputs. Each group also has a mask of enable bits. Software changes a mask through a set port, where writing 1 sets a bit, and a clear port, where writing 1 clears a bit. Zeros written to either port change nothing, so two drivers never need a read-modify-write on a shared mask.

All requests that are both pending and enabled are merged into one registered normal interrupt output. A single source may instead be steered to a separate registered fast-interrupt output. A control word selects that source by number and turns steering on. Source numbers run 0 to 63 over the peripheral groups, so source n sits in group n/32 at bit n%32. The basic group follows as 64 to 95. While a source is steered it never reaches the normal output.

Host access uses a zero-wait 32-bit word bus: a word address, write data, a write strobe and combinational read data.

Top module: `banked_intc`

## Requirements
- R1: After reset every enable mask and the fast-interrupt control word read zero, and both interrupt outputs are low.
- R2: Word 0 reads the basic group's input levels, words 1 and 2 read peripheral groups 0 and 1. Writes to these words change nothing.
- R3: Writing to an enable-set word (4, 5, 6 for group 0, group 1, basic) sets each mask bit written as 1 and leaves every bit written as 0 unchanged.
- R4: Writing to an enable-clear word (7, 8, 9 for group 0, group 1, basic) clears each mask bit written as 1. Reading either the set word or the clear word of a group returns that group's current mask.
- R5: The normal interrupt output goes high one clock after any source is both high and enabled, and is low one clock after no source is.
- R6: Source n of the peripheral range is input bit n, shown in pending word 1 + n/32 at bit n%32.
- R7: Control word 3 holds the steering enable in bit 7 and the source number in bits 6:0, where 64 to 95 name basic bits 0 to 31. While bit 7 is set, the fast-interrupt output follows the selected source's level with one clock of delay. Otherwise it is low.
- R8: While a source is steered, it is left out of the normal interrupt output even if its enable bit is set.
- R9: While steering is on, a control write that keeps bit 7 set does not change the selected number. A write with bit 7 clear turns steering off and stores the new number.
- R10: Writing all ones to the three enable-clear words and zero to the control word leaves both outputs low whatever the inputs do.
- R11: Word addresses 10 to 15 read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_wr | input | 1 | Write strobe, one word per cycle |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| periph_src | input | 64 | Peripheral request levels, bit n is source n |
| basic_src | input | 32 | Basic group request levels |
| irq_o | output | 1 | Registered normal interrupt |
| fiq_o | output | 1 | Registered fast interrupt |

## Verification
The hardest situation to reach is a source that is enabled for the normal path and also steered at the same moment. Without steering that source would raise the normal output, so the check only has meaning when this is the one active source. The stimulus first enables source 40 through the group-1 set word, steers it, and drives only that line. It then expects the fast output high and the normal output low. Clearing the control word must bring the normal output back. A further sequence tries to re-point the steering while it is enabled, then takes the legal route through a disabling write and selects a basic-group source.

// File: rtl/intc_pkg.sv
package intc_pkg;

   typedef enum logic [2:0] {
      RK_NONE,
      RK_PEND,
      RK_CTL,
      RK_EN,
      RK_DIS
   } reg_kind_e;

   typedef struct packed {
      reg_kind_e  kind;
      logic [7:0] grp;
   } reg_dec_t;

   // Word map for nb peripheral groups; group index nb is the basic group.
   function automatic reg_dec_t decode_word(input int unsigned a, input int unsigned nb);
      reg_dec_t d;
      d.kind = RK_NONE;
      d.grp  = '0;
      if (a == 0) begin
         d.kind = RK_PEND;
         d.grp  = 8'(nb);
      end else if (a <= nb) begin
         d.kind = RK_PEND;
         d.grp  = 8'(a - 1);
      end else if (a == nb + 1) begin
         d.kind = RK_CTL;
      end else if (a <= 2 * nb + 1) begin
         d.kind = RK_EN;
         d.grp  = 8'(a - nb - 2);
      end else if (a == 2 * nb + 2) begin
         d.kind = RK_EN;
         d.grp  = 8'(nb);
      end else if (a <= 3 * nb + 2) begin
         d.kind = RK_DIS;
         d.grp  = 8'(a - 2 * nb - 3);
      end else if (a == 3 * nb + 3) begin
         d.kind = RK_DIS;
         d.grp  = 8'(nb);
      end
      return d;
   endfunction

endpackage

// File: rtl/intc_mask_reg.sv
module intc_mask_reg #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         set_i,
   input  logic         clr_i,
   input  logic [W-1:0] bits_i,
   output logic [W-1:0] mask_o
);

   logic [W-1:0] mask_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         mask_q <= '0;
      else if (clr_i)
         mask_q <= mask_q & ~bits_i;
      else if (set_i)
         mask_q <= mask_q | bits_i;
   end

   assign mask_o = mask_q;

   AST_SET_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
      (set_i && !clr_i) |=> ((mask_o & $past(bits_i)) == $past(bits_i))); // R3
   AST_SET_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      (set_i && !clr_i) |=> ((mask_o & $past(mask_o)) == $past(mask_o))); // R3
   AST_CLR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> ((mask_o & $past(bits_i)) == '0)); // R4
   AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!set_i && !clr_i) |=> $stable(mask_o)); // R4

endmodule

// File: rtl/intc_fiq_route.sv
module intc_fiq_route #(
   parameter int W      = 32,
   parameter int NSRC   = 96,
   parameter int SEL_W  = 7,
   parameter int EN_BIT = 7
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_i,
   input  logic            en_bit_i,
   input  logic [SEL_W-1:0] sel_bits_i,
   input  logic [NSRC-1:0] src_i,
   output logic [W-1:0]    ctl_o,
   output logic [NSRC-1:0] route_o,
   output logic            fiq_o
);

   logic             en_q;
   logic [SEL_W-1:0] sel_q;
   logic             fiq_q;

   // The number is locked while steering is on; a disabling write re-opens it.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q  <= 1'b0;
         sel_q <= '0;
      end else if (wr_i) begin
         en_q <= en_bit_i;
         if (!en_q || !en_bit_i)
            sel_q <= sel_bits_i;
      end
   end

   always_comb begin
      ctl_o              = '0;
      ctl_o[SEL_W-1:0]   = sel_q;
      ctl_o[EN_BIT]      = en_q;
   end

   for (genvar s = 0; s < NSRC; s++) begin : g_route
      assign route_o[s] = en_q && (sel_q == SEL_W'(s));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         fiq_q <= 1'b0;
      else
         fiq_q <= |(route_o & src_i);
   end

   assign fiq_o = fiq_q;

   AST_SEL_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && en_q && en_bit_i) |=> $stable(sel_q)); // R9
   AST_SEL_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && !en_bit_i) |=> (sel_q == $past(sel_bits_i))); // R9
   AST_FIQ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !en_q |=> !fiq_o); // R7

endmodule

// File: rtl/intc_regbus.sv
module intc_regbus
   import intc_pkg::*;
#(
   parameter int W      = 32,
   parameter int NB     = 2,
   parameter int ADDR_W = 4,
   localparam int NG    = NB + 1
) (
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              wr_i,
   input  logic [NG*W-1:0]   pend_i,
   input  logic [NG*W-1:0]   en_i,
   input  logic [W-1:0]      ctl_i,
   output logic [W-1:0]      rdata_o,
   output logic [NG-1:0]     set_o,
   output logic [NG-1:0]     clr_o,
   output logic              ctl_wr_o
);

   reg_dec_t dec;

   always_comb dec = decode_word(32'(addr_i), NB);

   for (genvar g = 0; g < NG; g++) begin : g_strobe
      assign set_o[g] = wr_i && (dec.kind == RK_EN)  && (dec.grp == 8'(g));
      assign clr_o[g] = wr_i && (dec.kind == RK_DIS) && (dec.grp == 8'(g));
   end

   assign ctl_wr_o = wr_i && (dec.kind == RK_CTL);

   always_comb begin
      rdata_o = '0;
      for (int g = 0; g < NG; g++) begin
         if (dec.grp == 8'(g)) begin
            if (dec.kind == RK_PEND)
               rdata_o = pend_i[g*W +: W];
            else if (dec.kind == RK_EN || dec.kind == RK_DIS)
               rdata_o = en_i[g*W +: W];
         end
      end
      if (dec.kind == RK_CTL)
         rdata_o = ctl_i;
   end

endmodule

// File: rtl/banked_intc.sv
module banked_intc #(
   parameter int W      = 32,
   parameter int NB     = 2,
   parameter int ADDR_W = 4,
   parameter int EN_BIT = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [W-1:0]      bus_wdata,
   input  logic              bus_wr,
   output logic [W-1:0]      bus_rdata,
   input  logic [NB*W-1:0]   periph_src,
   input  logic [W-1:0]      basic_src,
   output logic              irq_o,
   output logic              fiq_o
);

   localparam int NG    = NB + 1;
   localparam int NSRC  = NG * W;
   localparam int SEL_W = $clog2(NSRC);
   localparam int NREG  = 3 * NB + 4;

   if (NB < 1 || NB > 254) begin : g_bad_nb
      $error("banked_intc: NB out of range");
   end
   if (EN_BIT >= W || EN_BIT < SEL_W) begin : g_bad_en
      $error("banked_intc: EN_BIT must lie above the select field and inside the word");
   end
   if ((1 << ADDR_W) < NREG) begin : g_bad_addr
      $error("banked_intc: ADDR_W too small for the register map");
   end

   logic [NSRC-1:0] src_all;
   logic [NSRC-1:0] en_all;
   logic [NSRC-1:0] route;
   logic [NG-1:0]   set_v;
   logic [NG-1:0]   clr_v;
   logic            ctl_wr;
   logic [W-1:0]    ctl_word;
   logic            irq_q;

   assign src_all = {basic_src, periph_src};

   intc_regbus #(.W(W), .NB(NB), .ADDR_W(ADDR_W)) u_bus (
      .addr_i   (bus_addr),
      .wr_i     (bus_wr),
      .pend_i   (src_all),
      .en_i     (en_all),
      .ctl_i    (ctl_word),
      .rdata_o  (bus_rdata),
      .set_o    (set_v),
      .clr_o    (clr_v),
      .ctl_wr_o (ctl_wr)
   );

   for (genvar g = 0; g < NG; g++) begin : g_mask
      intc_mask_reg #(.W(W)) u_mask (
         .clk    (clk),
         .rst_n  (rst_n),
         .set_i  (set_v[g]),
         .clr_i  (clr_v[g]),
         .bits_i (bus_wdata),
         .mask_o (en_all[g*W +: W])
      );
   end

   intc_fiq_route #(.W(W), .NSRC(NSRC), .SEL_W(SEL_W), .EN_BIT(EN_BIT)) u_fiq (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_i       (ctl_wr),
      .en_bit_i   (bus_wdata[EN_BIT]),
      .sel_bits_i (bus_wdata[SEL_W-1:0]),
      .src_i      (src_all),
      .ctl_o      (ctl_word),
      .route_o    (route),
      .fiq_o      (fiq_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         irq_q <= 1'b0;
      else
         irq_q <= |(src_all & en_all & ~route);
   end

   assign irq_o = irq_q;

   AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (en_all == '0) |=> !irq_o); // R5
   AST_ROUTED_NOT_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      ((route != '0) && ((src_all & en_all) == route)) |=> !irq_o); // R8
   AST_QUIET_WHEN_SILENCED: assert property (@(posedge clk) disable iff (!rst_n)
      ((en_all == '0) && (route == '0)) |=> (!irq_o && !fiq_o)); // R10

endmodule

// File: tb/sim_banked_intc.sv
module sim_banked_intc;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic        bus_wr = 1'b0;
   logic [31:0] bus_rdata;
   logic [63:0] periph_src = '0;
   logic [31:0] basic_src = '0;
   logic        irq_o;
   logic        fiq_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   typedef struct {
      int          kind;   // 0 read data, 1 irq, 2 fiq
      logic [31:0] exp;
      string       tag;
   } item_t;

   item_t sb[$];

   always #5 clk = ~clk;

   banked_intc u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_wr    (bus_wr),
      .bus_rdata (bus_rdata),
      .periph_src(periph_src),
      .basic_src (basic_src),
      .irq_o     (irq_o),
      .fiq_o     (fiq_o)
   );

   // Monitor: compares queued expectations away from the active edge.
   initial begin
      forever begin
         @(negedge clk);
         while (sb.size() > 0) begin
            item_t it;
            logic [31:0] act;
            it = sb.pop_front();
            act = (it.kind == 0) ? bus_rdata :
                  (it.kind == 1) ? {31'b0, irq_o} : {31'b0, fiq_o};
            checks++;
            if (act !== it.exp) begin
               errors++;
               $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
            end
         end
      end
   end

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      @(posedge clk); #1;
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(posedge clk); #1;
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, input logic [31:0] e, input string tag);
      item_t it;
      @(posedge clk); #1;
      bus_addr = a;
      it.kind = 0; it.exp = e; it.tag = tag;
      sb.push_back(it);
   endtask

   task automatic expect_out(input int kind, input logic e, input string tag);
      item_t it;
      @(posedge clk); #1;
      it.kind = kind; it.exp = {31'b0, e}; it.tag = tag;
      sb.push_back(it);
   endtask

   task automatic drive(input logic [63:0] p, input logic [31:0] b);
      @(posedge clk); #1;
      periph_src = p; basic_src = b;
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1 reset state
      rd(4'd4, 32'h0, "R1 group0 mask");
      rd(4'd6, 32'h0, "R1 basic mask");
      rd(4'd3, 32'h0, "R1 control word");
      expect_out(1, 1'b0, "R1 irq low");
      expect_out(2, 1'b0, "R1 fiq low");

      // R2 pending words follow inputs, writes ignored
      drive(64'hA5A5_0000_0000_1234, 32'h8000_0001);
      rd(4'd1, 32'h0000_1234, "R2 group0 pending");
      rd(4'd2, 32'hA5A5_0000, "R2 group1 pending");
      rd(4'd0, 32'h8000_0001, "R2 basic pending");
      wr(4'd1, 32'hFFFF_FFFF);
      rd(4'd1, 32'h0000_1234, "R2 write to pending ignored");
      expect_out(1, 1'b0, "R5 no enable no irq");
      drive(64'h0, 32'h0);

      // R3 set-only enables
      wr(4'd4, 32'h0000_00F0);
      wr(4'd4, 32'h0000_0003);
      rd(4'd4, 32'h0000_00F3, "R3 bits accumulate");
      wr(4'd4, 32'h0);
      rd(4'd4, 32'h0000_00F3, "R3 zero write keeps mask");

      // R4 clear-only disables, both words read mask
      wr(4'd7, 32'h0000_0010);
      rd(4'd4, 32'h0000_00E3, "R4 bit cleared via set word");
      rd(4'd7, 32'h0000_00E3, "R4 clear word reads mask");

      // R5 normal output
      drive(64'h2, 32'h0);
      expect_out(1, 1'b1, "R5 enabled source raises irq");
      drive(64'h100, 32'h0);
      expect_out(1, 1'b0, "R5 disabled source ignored");
      wr(4'd5, 32'h8000_0000);
      drive(64'd1 << 63, 32'h0);
      expect_out(1, 1'b1, "R5 source 63 group1");
      drive(64'h0, 32'h0);
      wr(4'd6, 32'h1);
      drive(64'h0, 32'h1);
      expect_out(1, 1'b1, "R5 basic source");
      drive(64'h0, 32'h0);
      expect_out(1, 1'b0, "R5 irq drops");

      // R6 numbering
      drive(64'd1 << 40, 32'h0);
      rd(4'd2, 32'h0000_0100, "R6 source 40 in group1 bit 8");
      rd(4'd1, 32'h0, "R6 group0 empty");

      // R7 steering
      wr(4'd3, 32'h0000_00A8);
      rd(4'd3, 32'h0000_00A8, "R7 control readback");
      expect_out(2, 1'b1, "R7 fiq follows source 40");
      expect_out(1, 1'b0, "R7 irq stays low");
      drive(64'h0, 32'h0);
      expect_out(2, 1'b0, "R7 fiq follows low level");

      // R8 steered source excluded from irq
      wr(4'd5, 32'h0000_0100);
      drive(64'd1 << 40, 32'h0);
      expect_out(1, 1'b0, "R8 steered source kept off irq");
      expect_out(2, 1'b1, "R8 fiq high");
      wr(4'd3, 32'h0);
      expect_out(1, 1'b1, "R8 irq returns after unsteer");
      expect_out(2, 1'b0, "R10 fiq off after control zero");

      // R9 selection lock
      wr(4'd3, 32'h0000_00A8);
      wr(4'd3, 32'h0000_00C1);
      rd(4'd3, 32'h0000_00A8, "R9 number locked while on");
      expect_out(2, 1'b1, "R9 fiq still on source 40");
      wr(4'd3, 32'h0000_0041);
      rd(4'd3, 32'h0000_0041, "R9 disabling write takes number");
      wr(4'd3, 32'h0000_00C1);
      rd(4'd3, 32'h0000_00C1, "R9 re-enabled on new number");
      drive(64'h0, 32'h2);
      expect_out(2, 1'b1, "R7 fiq follows basic bit 1");
      expect_out(1, 1'b0, "R5 basic bit1 not enabled");

      // R10 silence sequence
      drive(64'hFFFF_FFFF_FFFF_FFFF, 32'hFFFF_FFFF);
      expect_out(1, 1'b1, "R10 irq before silence");
      wr(4'd7, 32'hFFFF_FFFF);
      wr(4'd8, 32'hFFFF_FFFF);
      wr(4'd9, 32'hFFFF_FFFF);
      wr(4'd3, 32'h0);
      expect_out(1, 1'b0, "R10 irq silenced");
      expect_out(2, 1'b0, "R10 fiq silenced");
      rd(4'd5, 32'h0, "R10 group1 mask zero");
      rd(4'd9, 32'h0, "R10 basic mask zero");

      // R11 unmapped words
      rd(4'd10, 32'h0, "R11 word 10");
      rd(4'd15, 32'h0, "R11 word 15");

      @(negedge clk);
      @(negedge clk);
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule